// File: doc/BRIEF.md
# Extended Match Channel Bank

This block adds eight match channels, numbered 4 through 11, to a system timer. Each channel holds a 32-bit counter, a 32-bit match value and a control word. The control word picks which rate tick advances the channel and whether the channel compares against its own counter or against the counter of the first channel in its group. It also sets whether a match clears the counter and whether the channel stays armed after it fires.

The block has no clock dividers. It takes one single-cycle enable input per rate (32768 Hz, 1 kHz, 1 Hz, 1 MHz and an external source) and counts on the cycles where the selected enable is high. Software reaches every register through a simple 32-bit read/write port. Read data comes back one cycle after the read strobe.

Matches set bits 11:4 of a status word, gated by the matching bits of an enable word. These are the bit positions the base timer leaves free. One combined interrupt stays high while any of those status bits is set. Reading the counter of channel 9 or channel 11 can also latch the counter of its even neighbour into a snapshot register, so that a pair of counters can be sampled together.

Top module: `ext_match_bank`

## Requirements
- R1: Channel k (k = 0..7 for channels 4..11) has its match register at 0x80+4k, its counter at 0x40+4k and its control register at 0xC0+4k. The snapshot register is at 0x20, status at 0x14 and enable at 0x1C. Status and enable read back with their active bits in positions 11:4. Read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R2: Control bits [2:0] select the tick: 1 selects `tick_32k`, 2 `tick_1k`, 3 `tick_1hz`, 4 `tick_1m` and 5 `tick_ext`. A running counter rises by one on each cycle its tick is high. Codes 0, 6 and 7 hold the counter.
- R3: With control bit 7 set, a channel compares against its own counter. With bit 7 clear, channels 4–7 compare against counter 4, channels 8–9 against counter 8, and channels 10–11 against counter 10.
- R4: A channel with bit 7 clear that is not channel 4, 8 or 10 never advances its own counter.
- R5: A match happens when the compared counter steps onto the match value. If control bit 3 is set, the matching channel's own counter loads 0 at that step instead of the new value.
- R6: Without control bit 6 a channel fires once and then ignores further matches. With bit 6 set it fires on every match. Writing that channel's match, counter or control register arms it again.
- R7: Channels 4–7 keep control bits [7:0] and read higher bits as 0. Channels 8–11 keep bits [9:0]. On channels 8–11, bit 8 stops the counter.
- R8: A match on channel n sets status bit n only if enable bit n is set. Writing status clears each bit written as 1 (write-one-to-clear). A match in the same cycle as the clear wins.
- R9: `irq_o` is high exactly while any status bit 11:4 is set. Clearing some of them leaves it high until all are clear.
- R10: Reading the counter of channel 9 (or 11) while its control bit 9 is set copies the current counter 8 (or 10) into the snapshot register. With bit 9 clear the snapshot keeps its value.
- R11: After reset, every counter, match, control, status, enable and snapshot register reads 0, and `irq_o` is low.
- R12: Writing a counter loads the written value, overriding any tick or clear in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | 32768 Hz rate enable (rate code 1) |
| tick_1k | input | 1 | 1 kHz rate enable (rate code 2) |
| tick_1hz | input | 1 | 1 Hz rate enable (rate code 3) |
| tick_1m | input | 1 | 1 MHz rate enable (rate code 4) |
| tick_ext | input | 1 | External rate enable (rate code 5) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_o | output | 1 | Combined match interrupt |

## Verification
The hardest state to reach from the ports is a one-shot channel that has already fired. Showing that it stays silent needs the counter to pass through the match value a second time with no register write to that channel in between. Any such write would arm the channel again. The bench reaches this state by arming a channel with clear-on-match so that the counter wraps to 0 after the first hit. It then clears only the status and pulses the tick the same number of times again. After that it arms the channel again through the match register alone and shows that the channel fires once more. Follower channels are reached the same way: only the group owner's tick is pulsed, and the bench observes that the follower's own counter has not moved.

// File: rtl/emb_pkg.sv
package emb_pkg;
  localparam int N_CH   = 8;
  localparam int CTRL_W = 10;
  localparam int ST_LSB = 4;

  localparam int C_CLR  = 3;
  localparam int C_PER  = 6;
  localparam int C_SELF = 7;
  localparam int C_HALT = 8;
  localparam int C_SNAP = 9;

  localparam logic [7:0] A_SNAP  = 8'h20;
  localparam logic [7:0] A_STAT  = 8'h14;
  localparam logic [7:0] A_EN    = 8'h1C;
  localparam logic [7:0] A_CNT   = 8'h40;
  localparam logic [7:0] A_MATCH = 8'h80;
  localparam logic [7:0] A_CTRL  = 8'hC0;

  // Channel whose counter a group follower compares against
  function automatic int owner_of(input int k);
    if (k < 4)      return 0;
    else if (k < 6) return 4;
    else            return 6;
  endfunction
endpackage

// File: rtl/emb_channel.sv
module emb_channel
  import emb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit WIDE   = 1'b0,
  parameter bit OWNER  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        tick_by_code,
  input  logic              wr_match,
  input  logic              wr_count,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cmp_step,
  input  logic [DATA_W-1:0] cmp_nxt,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] match_o,
  output logic              own_step_o,
  output logic [DATA_W-1:0] own_nxt_o,
  output logic              hit_o
);
  localparam logic [CTRL_W-1:0] KEEP = WIDE ? CTRL_W'(10'h3FF) : CTRL_W'(10'h0FF);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] match_q, match_d;
  logic              armed_q, armed_d;
  logic              halted, may_run;

  always_comb begin
    halted     = WIDE && ctrl_q[C_HALT];
    may_run    = (ctrl_q[C_SELF] || OWNER) && !halted;
    own_step_o = may_run && tick_by_code[ctrl_q[2:0]];
    own_nxt_o  = cnt_q + DATA_W'(1);
    hit_o      = armed_q && cmp_step && (cmp_nxt == match_q);
  end

  always_comb begin
    ctrl_d  = wr_ctrl  ? (wdata[CTRL_W-1:0] & KEEP) : ctrl_q;
    match_d = wr_match ? wdata : match_q;
    if (wr_count)                    cnt_d = wdata;
    else if (hit_o && ctrl_q[C_CLR]) cnt_d = '0;
    else if (own_step_o)             cnt_d = own_nxt_o;
    else                             cnt_d = cnt_q;
    if (wr_match || wr_count || wr_ctrl) armed_d = 1'b1;
    else if (hit_o && !ctrl_q[C_PER])    armed_d = 1'b0;
    else                                 armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cnt_q   <= '0;
      match_q <= '0;
      armed_q <= 1'b1;
    end else begin
      ctrl_q  <= ctrl_d;
      cnt_q   <= cnt_d;
      match_q <= match_d;
      armed_q <= armed_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign cnt_o   = cnt_q;
  assign match_o = match_q;
endmodule

// File: rtl/emb_status.sv
module emb_status
  import emb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_wr,
  input  logic            st_wr,
  input  logic [N_CH-1:0] wbits,
  input  logic [N_CH-1:0] hits,
  output logic [N_CH-1:0] en_o,
  output logic [N_CH-1:0] st_o,
  output logic            irq_o
);
  logic [N_CH-1:0] en_q, en_d, st_q, st_d, clr;

  always_comb begin
    clr  = st_wr ? wbits : '0;
    en_d = en_wr ? wbits : en_q;
    st_d = (st_q & ~clr) | (hits & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      en_q <= en_d;
      st_q <= st_d;
    end
  end

  assign en_o  = en_q;
  assign st_o  = st_q;
  assign irq_o = |st_q;
endmodule

// File: rtl/ext_match_bank.sv
module ext_match_bank
  import emb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              tick_1k,
  input  logic              tick_1hz,
  input  logic              tick_1m,
  input  logic              tick_ext,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam int ST_W = N_CH + ST_LSB;

  logic [7:0]        tick_by_code;
  logic [CTRL_W-1:0] ctrl_q  [N_CH];
  logic [DATA_W-1:0] cnt_q   [N_CH];
  logic [DATA_W-1:0] match_q [N_CH];
  logic [DATA_W-1:0] own_nxt [N_CH];
  logic [DATA_W-1:0] cmp_nxt [N_CH];
  logic              own_step[N_CH];
  logic              cmp_step[N_CH];
  logic              hit     [N_CH];
  logic              cnt_wr  [N_CH];
  logic              mt_wr   [N_CH];
  logic              ct_wr   [N_CH];
  logic [N_CH-1:0]   hits, en_q, st_q;
  logic              st_wr, en_wr;
  logic [DATA_W-1:0] snap_q, snap_d, rd_mux, rdata_q;

  assign tick_by_code = {2'b00, tick_ext, tick_1m, tick_1hz, tick_1k, tick_32k, 1'b0};
  assign st_wr = reg_wr && (reg_addr == ADDR_W'(A_STAT));
  assign en_wr = reg_wr && (reg_addr == ADDR_W'(A_EN));

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    localparam int OW = owner_of(k);

    assign cnt_wr[k] = reg_wr && (reg_addr == ADDR_W'(A_CNT   + 8'(4 * k)));
    assign mt_wr[k]  = reg_wr && (reg_addr == ADDR_W'(A_MATCH + 8'(4 * k)));
    assign ct_wr[k]  = reg_wr && (reg_addr == ADDR_W'(A_CTRL  + 8'(4 * k)));

    assign cmp_step[k] = ctrl_q[k][C_SELF] ? own_step[k] : own_step[OW];
    assign cmp_nxt[k]  = ctrl_q[k][C_SELF] ? own_nxt[k]  : own_nxt[OW];
    assign hits[k]     = hit[k];

    emb_channel #(
      .DATA_W(DATA_W),
      .WIDE  (k >= 4),
      .OWNER (OW == k)
    ) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_by_code(tick_by_code),
      .wr_match    (mt_wr[k]),
      .wr_count    (cnt_wr[k]),
      .wr_ctrl     (ct_wr[k]),
      .wdata       (reg_wdata),
      .cmp_step    (cmp_step[k]),
      .cmp_nxt     (cmp_nxt[k]),
      .ctrl_o      (ctrl_q[k]),
      .cnt_o       (cnt_q[k]),
      .match_o     (match_q[k]),
      .own_step_o  (own_step[k]),
      .own_nxt_o   (own_nxt[k]),
      .hit_o       (hit[k])
    );
  end

  emb_status u_status (
    .clk  (clk),
    .rst_n(rst_n),
    .en_wr(en_wr),
    .st_wr(st_wr),
    .wbits(reg_wdata[ST_W-1:ST_LSB]),
    .hits (hits),
    .en_o (en_q),
    .st_o (st_q),
    .irq_o(irq_o)
  );

  // Snapshot: reading counter 9 or 11 with its snap bit captures the even neighbour
  always_comb begin
    snap_d = snap_q;
    for (int k = 1; k < N_CH; k += 2) begin
      if (k >= 5 && reg_rd && ctrl_q[k][C_SNAP] &&
          reg_addr == ADDR_W'(A_CNT + 8'(4 * k)))
        snap_d = cnt_q[k-1];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(A_SNAP)) rd_mux = snap_q;
    if (reg_addr == ADDR_W'(A_STAT)) rd_mux = DATA_W'({st_q, 4'b0000});
    if (reg_addr == ADDR_W'(A_EN))   rd_mux = DATA_W'({en_q, 4'b0000});
    for (int k = 0; k < N_CH; k++) begin
      if (reg_addr == ADDR_W'(A_CNT   + 8'(4 * k))) rd_mux = cnt_q[k];
      if (reg_addr == ADDR_W'(A_MATCH + 8'(4 * k))) rd_mux = match_q[k];
      if (reg_addr == ADDR_W'(A_CTRL  + 8'(4 * k))) rd_mux = DATA_W'(ctrl_q[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      rdata_q <= '0;
    end else begin
      snap_q <= snap_d;
      if (reg_rd) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/emb_checker.sv
module emb_checker
  import emb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              st_wr,
  input logic [N_CH-1:0]   st_q,
  input logic [N_CH-1:0]   en_q,
  input logic [CTRL_W-1:0] ctrl_q [N_CH],
  input logic [DATA_W-1:0] cnt_q  [N_CH],
  input logic              cnt_wr [N_CH]
);
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !st_wr) |=> irq_o);

  for (genvar k = 0; k < N_CH; k++) begin : g_a
    assert_stop_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_q[k][2:0] == 3'd0 || ctrl_q[k][2:0] >= 3'd6) &&
       !cnt_wr[k] && !ctrl_q[k][C_CLR]) |=> $stable(cnt_q[k]));

    assert_en_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q[k]) |-> $past(en_q[k]));

    if (owner_of(k) != k) begin : g_fol
      assert_follower_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[k][C_SELF] && !cnt_wr[k] && !ctrl_q[k][C_CLR]) |=> $stable(cnt_q[k]));
    end

    if (k >= 4) begin : g_wide
      assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[k][C_HALT] && !cnt_wr[k] && !ctrl_q[k][C_CLR]) |=> $stable(cnt_q[k]));
    end
  end
endmodule

bind ext_match_bank emb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .irq_o (irq_o),
  .st_wr (st_wr),
  .st_q  (st_q),
  .en_q  (en_q),
  .ctrl_q(ctrl_q),
  .cnt_q (cnt_q),
  .cnt_wr(cnt_wr)
);

// File: tb/ext_match_bank_tb.sv
module ext_match_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_32k = 0, tick_1k = 0, tick_1hz = 0, tick_1m = 0, tick_ext = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  ext_match_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .tick_32k(tick_32k), .tick_1k(tick_1k), .tick_1hz(tick_1hz),
    .tick_1m(tick_1m), .tick_ext(tick_ext),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic logic [7:0] a_cnt(input int k);   return 8'h40 + 8'(4*k); endfunction
  function automatic logic [7:0] a_match(input int k); return 8'h80 + 8'(4*k); endfunction
  function automatic logic [7:0] a_ctrl(input int k);  return 8'hC0 + 8'(4*k); endfunction
  localparam logic [7:0] SNAP = 8'h20, STAT = 8'h14, EN = 8'h1C;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(input int code, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_32k = (code == 1); tick_1k = (code == 2); tick_1hz = (code == 3);
      tick_1m  = (code == 4); tick_ext = (code == 5);
      @(negedge clk);
      {tick_32k, tick_1k, tick_1hz, tick_1m, tick_ext} = '0;
    end
  endtask

  task automatic clear_all();
    for (int k = 0; k < 8; k++) wr(a_ctrl(k), 0);
    for (int k = 0; k < 8; k++) begin
      wr(a_cnt(k), 0);
      wr(a_match(k), 32'hFFFF_FFFF);
    end
    wr(STAT, 32'hFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11: reset state
    chk("R11 irq", {31'b0, irq_o}, 0);
    for (int k = 0; k < 8; k++) begin
      rdchk("R11 cnt", a_cnt(k), 0);
      rdchk("R11 match", a_match(k), 0);
      rdchk("R11 ctrl", a_ctrl(k), 0);
    end
    rdchk("R11 status", STAT, 0);
    rdchk("R11 enable", EN, 0);
    rdchk("R11 snap", SNAP, 0);

    // R7: kept control widths per channel
    for (int k = 0; k < 8; k++) begin
      wr(a_ctrl(k), 32'hFFFF_FFFF);
      rdchk("R7 ctrl mask", a_ctrl(k), (k < 4) ? 32'hFF : 32'h3FF);
      wr(a_ctrl(k), 0);
    end

    // R1/R12: distinct addresses hold distinct values
    for (int k = 0; k < 8; k++) begin
      wr(a_cnt(k), 32'h1000 * k + k);
      wr(a_match(k), 32'hA000_0000 + k);
    end
    for (int k = 0; k < 8; k++) begin
      rdchk("R12 cnt load", a_cnt(k), 32'h1000 * k + k);
      rdchk("R1 match map", a_match(k), 32'hA000_0000 + k);
    end
    wr(EN, 32'hFFFF_FFFF);
    rdchk("R1 enable bits 11:4", EN, 32'hFF0);
    wr(EN, 0);

    // R2: every rate code on every channel, self counter selected
    for (int k = 0; k < 8; k++) begin
      for (int code = 0; code < 8; code++) begin
        wr(a_ctrl(k), 32'h80 | code);
        wr(a_cnt(k), 0);
        for (int t = 1; t <= 5; t++) pulse(t, 1);
        rdchk($sformatf("R2 ch%0d code%0d", k + 4, code), a_cnt(k),
              (code >= 1 && code <= 5) ? 1 : 0);
      end
      wr(a_ctrl(k), 0);
    end

    // R7: bit 8 halts a wide channel
    clear_all();
    wr(a_ctrl(4), 32'h181);
    pulse(1, 2);
    rdchk("R7 halt", a_cnt(4), 0);

    // R3/R4: owner counts, follower's own counter holds
    clear_all();
    wr(a_ctrl(0), 1);
    wr(a_ctrl(1), 1);
    pulse(1, 3);
    rdchk("R3 owner counts", a_cnt(0), 3);
    rdchk("R4 follower holds", a_cnt(1), 0);

    // R3/R5: follower ch6 matches on counter 4
    wr(EN, 32'hFF0);
    wr(a_match(2), 5);
    pulse(1, 1);
    rdchk("R5 no early match", STAT, 0);
    pulse(1, 1);
    rdchk("R3 follower match", STAT, 32'h040);
    chk("R9 irq set", {31'b0, irq_o}, 1);
    wr(STAT, 32'h040);
    rdchk("R8 w1c", STAT, 0);
    chk("R9 irq clear", {31'b0, irq_o}, 0);

    // R3: group 8 follower ch9
    wr(a_ctrl(4), 2);
    wr(a_cnt(4), 0);
    wr(a_match(5), 1);
    pulse(2, 1);
    rdchk("R3 group8 follower", STAT, 32'h200);
    wr(STAT, 32'hFFF);

    // R8: disabled channel match leaves status clear
    clear_all();
    wr(EN, 0);
    wr(a_ctrl(6), 32'h81);
    wr(a_match(6), 1);
    pulse(1, 1);
    rdchk("R8 masked status", STAT, 0);
    chk("R8 masked irq", {31'b0, irq_o}, 0);

    // R5/R6: one-shot with clear-on-match
    clear_all();
    wr(EN, 32'hFF0);
    wr(a_ctrl(0), 32'h89);
    wr(a_match(0), 3);
    pulse(1, 3);
    rdchk("R5 status hit", STAT, 32'h010);
    rdchk("R5 clear on match", a_cnt(0), 0);
    wr(STAT, 32'h010);
    pulse(1, 3);
    rdchk("R6 one-shot silent", STAT, 0);
    rdchk("R6 one-shot no clear", a_cnt(0), 3);

    // R6: periodic
    wr(a_ctrl(0), 32'hC9);
    wr(a_cnt(0), 0);
    pulse(1, 3);
    rdchk("R6 periodic first", STAT, 32'h010);
    wr(STAT, 32'h010);
    pulse(1, 3);
    rdchk("R6 periodic second", STAT, 32'h010);
    wr(STAT, 32'hFFF);

    // R6: re-arm through match write only
    wr(a_ctrl(0), 32'h89);
    wr(a_cnt(0), 0);
    wr(a_match(0), 2);
    pulse(1, 2);
    rdchk("R6 arm fire", STAT, 32'h010);
    wr(STAT, 32'h010);
    pulse(1, 2);
    rdchk("R6 spent", STAT, 0);
    wr(a_match(0), 4);
    pulse(1, 2);
    rdchk("R6 rearm by match write", STAT, 32'h010);
    wr(STAT, 32'hFFF);

    // R9: irq held until every bit cleared
    clear_all();
    wr(EN, 32'hFF0);
    wr(a_ctrl(0), 32'h81);
    wr(a_match(0), 1);
    wr(a_ctrl(6), 32'h81);
    wr(a_match(6), 1);
    pulse(1, 1);
    rdchk("R8 two bits", STAT, 32'h410);
    wr(STAT, 32'h010);
    rdchk("R9 partial clear", STAT, 32'h400);
    chk("R9 irq held", {31'b0, irq_o}, 1);
    wr(STAT, 32'h400);
    chk("R9 irq dropped", {31'b0, irq_o}, 0);

    // R10: snapshot
    clear_all();
    wr(a_cnt(4), 32'h1234_5678);
    wr(a_ctrl(5), 32'h200);
    rdchk("R10 read ch9", a_cnt(5), 0);
    rdchk("R10 snap ch8", SNAP, 32'h1234_5678);
    wr(a_cnt(6), 32'h0000_CAFE);
    rdchk("R10 read ch11 no snap", a_cnt(7), 0);
    rdchk("R10 snap kept", SNAP, 32'h1234_5678);
    wr(a_ctrl(7), 32'h200);
    rdchk("R10 read ch11", a_cnt(7), 0);
    rdchk("R10 snap ch10", SNAP, 32'h0000_CAFE);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule